// File: doc/BRIEF.md
# Virtual Function Enable and Routing Register Block

This block holds the configuration registers of a single-root I/O virtualization capability that sits inside a physical function's extended configuration space. Configuration reads and writes arrive as dword-aligned byte addresses with byte enables. The block decides whether each access falls inside the capability window. It applies a write mask to every field and keeps the resulting state in registers.

Software programs a requested virtual function count and a system page size. It then sets the enable bit in the control word. At that moment the block decides how many virtual functions become active, and it holds that count until software clears the enable bit or reset is applied. A lookup port takes a virtual function index and returns, one cycle later, that function's routing ID and a valid flag. The routing ID is the physical function's routing ID plus the first-function offset plus the index times the stride. The port also returns the identity word that a virtual function presents in place of its vendor and device IDs.

All control outputs come straight from registers. Read data appears one cycle after the request.

Top module: `sriov_cap_regs`

## Requirements
- R1: In the control dword (capability offset 0x08) only bit 0 (function enable), bit 3 (function memory decode enable) and bit 4 (alternative routing hierarchy) can be written. Every other bit reads 0, bits 31:16 read 0, and the three writable bits also drive the outputs `vf_enable`, `vf_mem_en` and `ari_hier`.
- R2: The requested count at offset 0x10 bits 15:0 is writable in all 16 bits, with each byte gated by its byte enable. Bits 31:16 read 0.
- R3: The following fields are read-only, come from parameters, and ignore writes: offset 0x0C holds {total[31:16], initial[15:0]}; offset 0x14 holds {stride[31:16], first offset[15:0]}; offset 0x18 holds the function device ID in bits 31:16 with bits 15:0 reading 0; offset 0x1C holds the supported page sizes.
- R4: The system page size at offset 0x20 resets to 0x00000001. Its write mask equals the supported page sizes (default 0x00000553), and bits outside the mask keep their value.
- R5: A control write with byte enable 0 set and bit 0 = 1, while no functions are active, sets the active count to the requested count if that count is at most the total, and to 0 otherwise. Once functions are active, the active count does not follow later changes to the requested count.
- R6: A control write with byte enable 0 set and bit 0 = 0, while functions are active, drops the active count to 0. A control write with byte enable 0 clear never changes the active count.
- R7: One cycle after `vf_idx` is presented, `vf_rid_valid` is 1 exactly when the index is below the active count. `vf_rid` then equals (`pf_rid` + first offset + index × stride) modulo 2^16, and reads 0 when not valid.
- R8: One cycle after a valid lookup, `vf_id_word` is 0xFFFFFFFF (vendor and device ID both 0xFFFF). It is 0 for an invalid lookup.
- R9: An access whose address is below the capability base, or at or beyond base + 0x40, changes no register. A read of such an address returns 0.
- R10: Synchronous reset clears the control word, the requested count and the active count, and sets the system page size to 0x00000001.
- R11: `rd_valid` pulses exactly one cycle after each read request, with `rd_data` carrying the addressed dword. Unassigned dwords inside the window read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Configuration access request |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | ADDR_W | Byte address in configuration space, low two bits ignored |
| cfg_be | input | 4 | Byte enables for a write |
| cfg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| pf_rid | input | 16 | Routing ID of the physical function |
| vf_idx | input | 16 | Virtual function index to look up |
| num_active | output | 16 | Number of active virtual functions |
| vf_enable | output | 1 | Control bit 0 |
| vf_mem_en | output | 1 | Control bit 3 |
| ari_hier | output | 1 | Control bit 4 |
| vf_rid_valid | output | 1 | Looked-up index is active |
| vf_rid | output | 16 | Routing ID of the looked-up function |
| vf_id_word | output | 32 | Vendor/device identity word of the looked-up function |

## Verification
A wrong active count shows on `num_active` on the cycle after the control write that caused it. It also shows one cycle later on the lookup port, as a valid flag that is wrong at the boundary index. A corrupted field register or a wrong write mask shows on the next read of that dword, one cycle after the request. The bench therefore reads back each field right after it is written. Address decoding errors show as reads from outside the window that return non-zero data, or as a state change after a write that should have been dropped.

// File: rtl/sriov_regs_pkg.sv
package sriov_regs_pkg;
  // dword indices inside the capability window
  localparam logic [7:0] DW_CTRL  = 8'd2;
  localparam logic [7:0] DW_VFCNT = 8'd3;
  localparam logic [7:0] DW_NUMVF = 8'd4;
  localparam logic [7:0] DW_GEOM  = 8'd5;
  localparam logic [7:0] DW_DEVID = 8'd6;
  localparam logic [7:0] DW_SUPPG = 8'd7;
  localparam logic [7:0] DW_SYSPG = 8'd8;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_MEM_BIT = 3;
  localparam int CTRL_ARI_BIT = 4;
  localparam logic [15:0] CTRL_WMASK = 16'h0019;

  localparam logic [31:0] SYSPG_RESET = 32'h0000_0001;
  localparam logic [31:0] VF_ID_WORD  = 32'hFFFF_FFFF;
endpackage

// File: rtl/sriov_addr_dec.sv
module sriov_addr_dec #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CAP_BASE = 'h160,
  parameter int CAP_BYTES = 64
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_range,
  output logic [7:0]        dw_idx
);
  localparam logic [ADDR_W:0] CAP_END = {1'b0, CAP_BASE} + (ADDR_W+1)'(CAP_BYTES);

  logic [ADDR_W-1:0] rel;

  assign rel      = addr - CAP_BASE;
  assign in_range = (addr >= CAP_BASE) && ({1'b0, addr} < CAP_END);
  assign dw_idx   = 8'(rel >> 2);
endmodule

// File: rtl/sriov_masked_reg.sv
module sriov_masked_reg #(
  parameter int BYTES = 2,
  parameter logic [8*BYTES-1:0] WMASK = '1,
  parameter logic [8*BYTES-1:0] RESET = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [BYTES-1:0]   be,
  input  logic [8*BYTES-1:0] wdata,
  output logic [8*BYTES-1:0] q
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    localparam logic [7:0] LMASK  = WMASK[8*b +: 8];
    localparam logic [7:0] LRESET = RESET[8*b +: 8];
    logic [7:0] lane_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= LRESET;
      end else if (we && be[b]) begin
        lane_q <= (wdata[8*b +: 8] & LMASK) | (lane_q & ~LMASK);
      end
    end

    assign q[8*b +: 8] = lane_q;
  end
endmodule

// File: rtl/sriov_vf_activate.sv
module sriov_vf_activate #(
  parameter logic [15:0] TOTAL_VFS = 16'd8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_eval,
  input  logic        en_wr,
  input  logic [15:0] req_count,
  output logic [15:0] active_q
);
  logic fits;

  assign fits = (req_count <= TOTAL_VFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
    end else if (ctrl_eval) begin
      if (active_q != '0) begin
        if (!en_wr) active_q <= '0;
      end else if (en_wr) begin
        active_q <= fits ? req_count : '0;
      end
    end
  end
endmodule

// File: rtl/sriov_rid_lookup.sv
module sriov_rid_lookup import sriov_regs_pkg::*; #(
  parameter logic [15:0] FIRST_OFF = 16'd1,
  parameter logic [15:0] STRIDE    = 16'd2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] pf_rid,
  input  logic [15:0] idx,
  input  logic [15:0] active,
  output logic        valid_q,
  output logic [15:0] rid_q,
  output logic [31:0] id_word_q
);
  logic [15:0] step;
  logic [15:0] rid_d;
  logic        hit;

  assign step  = idx * STRIDE;
  assign rid_d = pf_rid + FIRST_OFF + step;
  assign hit   = (idx < active);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      rid_q     <= '0;
      id_word_q <= '0;
    end else begin
      valid_q   <= hit;
      rid_q     <= hit ? rid_d : '0;
      id_word_q <= hit ? VF_ID_WORD : '0;
    end
  end
endmodule

// File: rtl/sriov_cap_regs.sv
module sriov_cap_regs import sriov_regs_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CAP_BASE = 'h160,
  parameter int CAP_BYTES = 64,
  parameter logic [15:0] TOTAL_VFS   = 16'd8,
  parameter logic [15:0] INITIAL_VFS = 16'd8,
  parameter logic [15:0] FIRST_OFF   = 16'd1,
  parameter logic [15:0] STRIDE      = 16'd2,
  parameter logic [15:0] VF_DEVID    = 16'h10CA,
  parameter logic [31:0] SUP_PG_SIZES = 32'h0000_0553
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_req,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic [15:0]       pf_rid,
  input  logic [15:0]       vf_idx,
  output logic [15:0]       num_active,
  output logic              vf_enable,
  output logic              vf_mem_en,
  output logic              ari_hier,
  output logic              vf_rid_valid,
  output logic [15:0]       vf_rid,
  output logic [31:0]       vf_id_word
);
  logic        in_range;
  logic [7:0]  dw;
  logic        wr_hit;
  logic        rd_req;
  logic        ctrl_eval;
  logic [15:0] ctrl_q;
  logic [15:0] req_q;
  logic [31:0] syspg_q;
  logic [31:0] rd_word;

  sriov_addr_dec #(
    .ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE), .CAP_BYTES(CAP_BYTES)
  ) dec_i (
    .addr(cfg_addr), .in_range(in_range), .dw_idx(dw)
  );

  assign wr_hit    = cfg_req && cfg_we && in_range;
  assign rd_req    = cfg_req && !cfg_we;
  assign ctrl_eval = wr_hit && (dw == DW_CTRL) && cfg_be[0];

  sriov_masked_reg #(.BYTES(2), .WMASK(CTRL_WMASK), .RESET(16'h0000)) ctrl_reg_i (
    .clk(clk), .rst(rst), .we(wr_hit && (dw == DW_CTRL)),
    .be(cfg_be[1:0]), .wdata(cfg_wdata[15:0]), .q(ctrl_q)
  );

  sriov_masked_reg #(.BYTES(2), .WMASK(16'hFFFF), .RESET(16'h0000)) req_reg_i (
    .clk(clk), .rst(rst), .we(wr_hit && (dw == DW_NUMVF)),
    .be(cfg_be[1:0]), .wdata(cfg_wdata[15:0]), .q(req_q)
  );

  sriov_masked_reg #(.BYTES(4), .WMASK(SUP_PG_SIZES), .RESET(SYSPG_RESET)) pg_reg_i (
    .clk(clk), .rst(rst), .we(wr_hit && (dw == DW_SYSPG)),
    .be(cfg_be), .wdata(cfg_wdata), .q(syspg_q)
  );

  sriov_vf_activate #(.TOTAL_VFS(TOTAL_VFS)) act_i (
    .clk(clk), .rst(rst), .ctrl_eval(ctrl_eval),
    .en_wr(cfg_wdata[CTRL_EN_BIT]), .req_count(req_q), .active_q(num_active)
  );

  sriov_rid_lookup #(.FIRST_OFF(FIRST_OFF), .STRIDE(STRIDE)) look_i (
    .clk(clk), .rst(rst), .pf_rid(pf_rid), .idx(vf_idx), .active(num_active),
    .valid_q(vf_rid_valid), .rid_q(vf_rid), .id_word_q(vf_id_word)
  );

  always_comb begin
    rd_word = '0;
    if (in_range) begin
      case (dw)
        DW_CTRL:  rd_word = {16'h0000, ctrl_q};
        DW_VFCNT: rd_word = {TOTAL_VFS, INITIAL_VFS};
        DW_NUMVF: rd_word = {16'h0000, req_q};
        DW_GEOM:  rd_word = {STRIDE, FIRST_OFF};
        DW_DEVID: rd_word = {VF_DEVID, 16'h0000};
        DW_SUPPG: rd_word = SUP_PG_SIZES;
        DW_SYSPG: rd_word = syspg_q;
        default:  rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_word;
    end
  end

  assign vf_enable = ctrl_q[CTRL_EN_BIT];
  assign vf_mem_en = ctrl_q[CTRL_MEM_BIT];
  assign ari_hier  = ctrl_q[CTRL_ARI_BIT];
endmodule

// File: rtl/sriov_cap_regs_chk.sv
module sriov_cap_regs_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CAP_BASE = 'h160,
  parameter int CAP_BYTES = 64,
  parameter logic [15:0] TOTAL_VFS = 16'd8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_req,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [3:0]        cfg_be,
  input logic              rd_valid,
  input logic [15:0]       vf_idx,
  input logic [15:0]       num_active,
  input logic              vf_enable,
  input logic              vf_rid_valid,
  input logic [31:0]       vf_id_word
);
  localparam logic [ADDR_W:0] CAP_END = {1'b0, CAP_BASE} + (ADDR_W+1)'(CAP_BYTES);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = CAP_BASE + ADDR_W'(8);

  logic outside;
  logic ctrl_b0_wr;

  assign outside    = (cfg_addr < CAP_BASE) || ({1'b0, cfg_addr} >= CAP_END);
  assign ctrl_b0_wr = cfg_req && cfg_we && cfg_be[0] &&
                      (cfg_addr[ADDR_W-1:2] == CTRL_ADDR[ADDR_W-1:2]);

  // R5
  active_le_total_chk: assert property (@(posedge clk) disable iff (rst)
    num_active <= TOTAL_VFS);

  // R6
  active_moves_on_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(num_active) |-> $past(ctrl_b0_wr));

  // R7
  lookup_bound_chk: assert property (@(posedge clk) disable iff (rst)
    vf_rid_valid |-> ($past(vf_idx) < $past(num_active)));

  // R8
  id_word_chk: assert property (@(posedge clk) disable iff (rst)
    vf_rid_valid |-> (vf_id_word == 32'hFFFF_FFFF));

  // R9
  outside_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && cfg_we && outside) |=> ($stable(num_active) && $stable(vf_enable)));

  // R11
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_we) |=> rd_valid);

  // R11
  rd_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(cfg_req && !cfg_we));
endmodule

bind sriov_cap_regs sriov_cap_regs_chk #(
  .ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE), .CAP_BYTES(CAP_BYTES), .TOTAL_VFS(TOTAL_VFS)
) chk_i (
  .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_be(cfg_be), .rd_valid(rd_valid), .vf_idx(vf_idx), .num_active(num_active),
  .vf_enable(vf_enable), .vf_rid_valid(vf_rid_valid), .vf_id_word(vf_id_word)
);

// File: tb/sriov_cap_regs_tb_top.sv
module sriov_cap_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] BASE  = 12'h160;
  localparam logic [15:0] TOTAL = 16'd8;
  localparam logic [15:0] INIT  = 16'd8;
  localparam logic [15:0] FOFF  = 16'd1;
  localparam logic [15:0] STRD  = 16'd2;
  localparam logic [15:0] DEVID = 16'h10CA;
  localparam logic [31:0] SUPPG = 32'h0000_0553;

  localparam logic [11:0] A_CTRL  = BASE + 12'h08;
  localparam logic [11:0] A_CNT   = BASE + 12'h0C;
  localparam logic [11:0] A_REQ   = BASE + 12'h10;
  localparam logic [11:0] A_GEOM  = BASE + 12'h14;
  localparam logic [11:0] A_DEVID = BASE + 12'h18;
  localparam logic [11:0] A_SUPPG = BASE + 12'h1C;
  localparam logic [11:0] A_SYSPG = BASE + 12'h20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_req = 1'b0, cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] pf_rid = 16'h0300, vf_idx = '0;
  logic rd_valid, vf_enable, vf_mem_en, ari_hier, vf_rid_valid;
  logic [31:0] rd_data, vf_id_word;
  logic [15:0] num_active, vf_rid;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sriov_cap_regs #(
    .ADDR_W(12), .CAP_BASE(BASE), .CAP_BYTES(64), .TOTAL_VFS(TOTAL),
    .INITIAL_VFS(INIT), .FIRST_OFF(FOFF), .STRIDE(STRD), .VF_DEVID(DEVID),
    .SUP_PG_SIZES(SUPPG)
  ) dut_i (
    .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .pf_rid(pf_rid), .vf_idx(vf_idx), .num_active(num_active), .vf_enable(vf_enable),
    .vf_mem_en(vf_mem_en), .ari_hier(ari_hier), .vf_rid_valid(vf_rid_valid),
    .vf_rid(vf_rid), .vf_id_word(vf_id_word)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every read return
  always @(negedge clk) begin
    logic [31:0] e;
    string t;
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R11: got unexpected read %h expected none", rd_data);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  task automatic cfg_write(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_req = 1'b0; cfg_we = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = 1'b0; cfg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    cfg_req = 1'b0;
  endtask

  function automatic logic [15:0] rid_of(input logic [15:0] pf, input logic [15:0] n);
    return pf + FOFF + n * STRD;
  endfunction

  task automatic lookup(input logic [15:0] n, input logic [15:0] active, input string tag);
    logic ok;
    ok = (n < active);
    @(negedge clk);
    vf_idx = n;
    @(negedge clk);
    check({tag, " valid"}, {31'd0, vf_rid_valid}, {31'd0, ok});
    check({tag, " rid"}, {16'd0, vf_rid}, {16'd0, ok ? rid_of(pf_rid, n) : 16'h0000});
    check({"R8 ", tag, " id word"}, vf_id_word, ok ? 32'hFFFF_FFFF : 32'h0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    check("R10 active after reset", {16'd0, num_active}, 32'd0);
    cfg_read(A_CTRL, 32'h0, "R10 control after reset");
    cfg_read(A_REQ, 32'h0, "R10 request count after reset");
    cfg_read(A_SYSPG, 32'h1, "R10 page size after reset");

    // R1 only three control bits writable; zero request gives zero active
    cfg_write(A_CTRL, 4'hF, 32'hFFFF_FFFF);
    cfg_read(A_CTRL, 32'h0000_0019, "R1 control mask");
    check("R1 control outputs", {29'd0, vf_enable, vf_mem_en, ari_hier}, 32'h7);
    check("R5 zero request", {16'd0, num_active}, 32'd0);
    cfg_write(A_CTRL, 4'h1, 32'h0);

    // R2 request count with byte lanes
    cfg_write(A_REQ, 4'h3, 32'hFFFF_0005);
    cfg_read(A_REQ, 32'h0000_0005, "R2 full write");
    cfg_write(A_REQ, 4'h2, 32'h0000_0300);
    cfg_read(A_REQ, 32'h0000_0305, "R2 upper lane only");
    cfg_write(A_REQ, 4'h3, 32'h0000_0005);

    // R3 read-only fields
    cfg_write(A_CNT, 4'hF, 32'hFFFF_FFFF);
    cfg_write(A_GEOM, 4'hF, 32'hFFFF_FFFF);
    cfg_write(A_DEVID, 4'hF, 32'hFFFF_FFFF);
    cfg_write(A_SUPPG, 4'hF, 32'hFFFF_FFFF);
    cfg_read(A_CNT, {TOTAL, INIT}, "R3 counts");
    cfg_read(A_GEOM, {STRD, FOFF}, "R3 offset and stride");
    cfg_read(A_DEVID, {DEVID, 16'h0}, "R3 device id");
    cfg_read(A_SUPPG, SUPPG, "R3 supported pages");

    // R4 page size mask
    cfg_write(A_SYSPG, 4'hF, 32'hFFFF_FFFF);
    cfg_read(A_SYSPG, SUPPG, "R4 masked all ones");
    cfg_write(A_SYSPG, 4'hF, 32'h0000_0010);
    cfg_read(A_SYSPG, 32'h0000_0010, "R4 single size");

    // R5 activation
    cfg_write(A_CTRL, 4'h1, 32'h1);
    check("R5 active after enable", {16'd0, num_active}, 32'd5);

    // R7 lookups
    lookup(16'd0, 16'd5, "R7 idx0");
    lookup(16'd4, 16'd5, "R7 idx4");
    lookup(16'd5, 16'd5, "R7 idx5 boundary");

    // R6 ignored without byte 0; R5 latched count
    cfg_write(A_CTRL, 4'h2, 32'h0);
    check("R6 no byte0 enable", {16'd0, num_active}, 32'd5);
    cfg_write(A_REQ, 4'h3, 32'h7);
    check("R5 latched count", {16'd0, num_active}, 32'd5);
    cfg_write(A_CTRL, 4'h1, 32'h0);
    check("R6 disable", {16'd0, num_active}, 32'd0);

    // R5 refusal above total, then exact total
    cfg_write(A_REQ, 4'h3, 32'h9);
    cfg_write(A_CTRL, 4'h1, 32'h1);
    check("R5 over total refused", {16'd0, num_active}, 32'd0);
    cfg_read(A_CTRL, 32'h1, "R1 enable bit stored");
    cfg_write(A_REQ, 4'h3, 32'h8);
    cfg_write(A_CTRL, 4'h1, 32'h1);
    check("R5 equal to total", {16'd0, num_active}, 32'd8);
    lookup(16'd7, 16'd8, "R7 idx7");
    lookup(16'd8, 16'd8, "R7 idx8 boundary");

    // R9 outside the window
    cfg_write(BASE - 12'h4, 4'hF, 32'h0);
    cfg_write(BASE + 12'h40, 4'hF, 32'h0);
    check("R9 outside writes", {15'd0, vf_enable, num_active}, {15'd0, 1'b1, 16'd8});
    cfg_read(BASE - 12'h4, 32'h0, "R9 read below base");
    cfg_read(BASE + 12'h40, 32'h0, "R9 read past end");
    cfg_read(BASE + 12'h24, 32'h0, "R11 unassigned dword");
    cfg_read(A_CTRL, 32'h1, "R9 control untouched");

    // R7 routing id wraps at 16 bits
    pf_rid = 16'hFFFA;
    lookup(16'd7, 16'd8, "R7 wrap");

    // R10 reset mid-run
    @(negedge clk);
    do_reset();
    check("R10 active cleared", {16'd0, num_active}, 32'd0);
    cfg_read(A_CTRL, 32'h0, "R10 control cleared");
    cfg_read(A_REQ, 32'h0, "R10 request cleared");
    cfg_read(A_SYSPG, 32'h1, "R10 page size restored");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11: got %0d pending reads expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule